// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. The host writes a small control word that switches the converter on, selects the conversion clock rate and the result alignment, and sets a start bit. The sequencer waits for the next conversion-clock tick and opens the sampling switch. It then drives a trial code to an external DAC and resolves one bit per conversion-clock period, most significant bit first, using the single-bit comparator answer.

When the last bit is resolved, the sequencer loads the 16-bit result pair, clears the start bit and raises a sticky done flag, all at the same clock edge. The host can abort a running conversion by writing the start bit as zero. An abort leaves the result pair untouched. After a completion or an abort the sampling switch closes, and acquisition is held off for two conversion-clock periods. While the converter is off, the two result bytes serve as plain host read/write storage.

The conversion clock is a one-cycle enable derived from the system clock. Its divide ratio is 2, 8 or 32.

Top module: `sar_seq_top`

## Requirements
- R1: The conversion-clock enable ticks once every 2, 8 or 32 system clocks when ctrl_wdata[4:3] is 0, 1 or 2..3. The number of clocks from the accepting control write to the rise of done_irq is between 11*D+1 and 12*D, where D is that ratio.
- R2: The bits are resolved from bit 9 down to bit 0. The comparator input is 1 when the analog input is at or above the trial code, and the final code equals the input level.
- R3: sample_open is high only while a conversion is running. It is never high while go_busy is low.
- R4: At completion, in one clock, the result pair is loaded, go_busy falls and done_irq rises.
- R5: A control write with ctrl_wdata[1]=0 during a conversion aborts it. go_busy and sample_open fall, done_irq is not set, and res_hi/res_lo keep their previous contents (the last result or the last host-written bytes).
- R6: After a completion or an abort, acq_on stays low for two conversion-clock periods. After a completion, acq_on returns exactly 2*D clocks later. Start requests made before acq_on returns are ignored.
- R7: ctrl_wdata[2]=1 places the result in bits 9:0 of {res_hi,res_lo}. ctrl_wdata[2]=0 places it in bits 15:6. All other bits are zero.
- R8: A write with res_we_hi or res_we_lo stores res_wdata into res_hi or res_lo. While the converter is off (ctrl_wdata[0]=0), these bytes read back unchanged.
- R9: A control write that sets ctrl_wdata[0]=1 and ctrl_wdata[1]=1 while the converter is off turns the converter on but starts no conversion.
- R10: done_irq stays set until irq_clr is pulsed.
- R11: Each conversion presents the trial code 10'h200 when sample_open rises.
- R12: After reset, go_busy, done_irq, sample_open, acq_on and adc_on are low and both result bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word: bit0 on, bit1 start/busy, bit2 right-align, bits4:3 rate |
| res_we_hi | input | 1 | Host write strobe for the upper result byte |
| res_we_lo | input | 1 | Host write strobe for the lower result byte |
| res_wdata | input | 8 | Host write data for the result bytes |
| irq_clr | input | 1 | Clears the done flag |
| cmp_in | input | 1 | Comparator answer, 1 = input at or above the trial code |
| dac_code | output | 10 | Trial code to the DAC |
| sample_open | output | 1 | Sampling switch open (conversion running) |
| acq_on | output | 1 | Acquisition allowed, a new start is accepted |
| adc_on | output | 1 | Converter on |
| go_busy | output | 1 | Start bit readback, high while a conversion is pending or running |
| done_irq | output | 1 | Sticky done flag |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |

## Verification
A wrong bit index or trial update in the SAR register shows up as a result word that differs from the applied level. This is visible at done_irq, about 11 conversion-clock periods after the start. A sequencer that loses its state or step count changes the time to completion, and the bench bounds that time to within one divider period. A recovery counter that is off by one moves the return of acq_on by a whole conversion-clock period. Abort and ignored-start faults appear within a clock or two as a busy flag that should not be set or a result byte that changed.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_CONV  = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_e;

  localparam int CTL_W = 5;

  // Host control word, MSB first: rate select, right-align, start, on.
  typedef struct packed {
    logic [1:0] rate;
    logic       rjust;
    logic       go;
    logic       on;
  } ctl_word_t;

endpackage

// File: rtl/sar_tad_div.sv
module sar_tad_div #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CW = $clog2(DIV_C);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(DIV_A - 1);
      2'd1:    lim = CW'(DIV_B - 1);
      default: lim = CW'(DIV_C - 1);
    endcase
  end

  // >= so that a ratio lowered mid-period still produces a tick at once
  assign tick = run && (cnt_q >= lim);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int BITS = 10,
  parameter int SW   = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          on_q,
  input  logic          ctl_we,
  input  logic          wr_on,
  input  logic          wr_go,
  output seq_state_e    state,
  output logic          load_sar,
  output logic          decide,
  output logic [SW-1:0] idx,
  output logic          complete
);
  localparam logic [SW-1:0] LAST = SW'(BITS);

  seq_state_e    st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic          rc_q, rc_d;
  logic          start_req;
  logic          stop_req;
  logic          kill;

  // A start needs the converter already on before this write.
  assign start_req = ctl_we && wr_go && wr_on && on_q;
  assign stop_req  = ctl_we && (!wr_go || !wr_on);
  assign kill      = ctl_we && !wr_on;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    rc_d   = rc_q;
    if (kill) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_req) st_d = ST_ARM;
        end
        ST_ARM: begin
          if (stop_req) begin
            st_d = ST_IDLE;
          end else if (tick) begin
            st_d   = ST_CONV;
            step_d = '0;
          end
        end
        ST_CONV: begin
          if (stop_req) begin
            st_d = ST_RECOV;
            rc_d = 1'b0;
          end else if (tick) begin
            if (step_q == LAST) begin
              st_d = ST_RECOV;
              rc_d = 1'b0;
            end else begin
              step_d = step_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (rc_q) st_d = ST_IDLE;
            else      rc_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      rc_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      rc_q   <= rc_d;
    end
  end

  // Step 0 is the settling period; steps 1..BITS resolve MSB..LSB.
  assign state    = st_q;
  assign idx      = LAST - step_q;
  assign load_sar = (st_q == ST_ARM) && tick && !stop_req;
  assign decide   = (st_q == ST_CONV) && tick && !stop_req && (step_q != '0);
  assign complete = (st_q == ST_CONV) && tick && !stop_req && (step_q == LAST);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int BITS = 10,
  parameter int SW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            decide,
  input  logic [SW-1:0]   idx,
  input  logic            cmp,
  output logic [BITS-1:0] code,
  output logic [BITS-1:0] resolved
);
  localparam logic [BITS-1:0] FIRST = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] code_q, code_d;
  logic [BITS-1:0] next_trial;

  always_comb begin
    resolved   = code_q;
    next_trial = '0;
    for (int i = 0; i < BITS; i++) begin
      if (SW'(i) == idx)     resolved[i]   = cmp;
      if (SW'(i + 1) == idx) next_trial[i] = 1'b1;
    end
  end

  always_comb begin
    if (load)        code_d = FIRST;
    else if (decide) code_d = resolved | next_trial;
    else             code_d = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int BITS  = 10,
  parameter int RES_W = 16,
  parameter int HW    = RES_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            rjust,
  input  logic [BITS-1:0] val,
  input  logic            we_hi,
  input  logic            we_lo,
  input  logic [HW-1:0]   wdata,
  output logic [HW-1:0]   hi,
  output logic [HW-1:0]   lo
);
  localparam int PAD = RES_W - BITS;

  logic [RES_W-1:0] right_w, left_w;
  logic [HW-1:0]    hi_q, hi_d, lo_q, lo_d;

  generate
    if (PAD > 0) begin : g_pad
      assign right_w = {{PAD{1'b0}}, val};
      assign left_w  = {val, {PAD{1'b0}}};
    end else begin : g_full
      assign right_w = val;
      assign left_w  = val;
    end
  endgenerate

  // Completion wins over a host byte write in the same cycle.
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (load) begin
      {hi_d, lo_d} = rjust ? right_w : left_w;
    end else begin
      if (we_hi) hi_d = wdata;
      if (we_lo) lo_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int BITS  = 10,
  parameter int RES_W = 16,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [CTL_W-1:0]   ctrl_wdata,
  input  logic               res_we_hi,
  input  logic               res_we_lo,
  input  logic [RES_W/2-1:0] res_wdata,
  input  logic               irq_clr,
  input  logic               cmp_in,
  output logic [BITS-1:0]    dac_code,
  output logic               sample_open,
  output logic               acq_on,
  output logic               adc_on,
  output logic               go_busy,
  output logic               done_irq,
  output logic [RES_W/2-1:0] res_hi,
  output logic [RES_W/2-1:0] res_lo
);
  localparam int SW = $clog2(BITS + 1);

  ctl_word_t       wd;
  logic            on_q, on_d;
  logic            rj_q, rj_d;
  logic [1:0]      rate_q, rate_d;
  logic            done_q, done_d;
  logic            tick;
  seq_state_e      state;
  logic            load_sar;
  logic            decide;
  logic            complete;
  logic [SW-1:0]   idx;
  logic [BITS-1:0] resolved;

  assign wd = ctl_word_t'(ctrl_wdata);

  always_comb begin
    on_d   = on_q;
    rj_d   = rj_q;
    rate_d = rate_q;
    if (ctrl_we) begin
      on_d   = wd.on;
      rj_d   = wd.rjust;
      rate_d = wd.rate;
    end
    if (complete)     done_d = 1'b1;
    else if (irq_clr) done_d = 1'b0;
    else              done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      rj_q   <= 1'b0;
      rate_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      on_q   <= on_d;
      rj_q   <= rj_d;
      rate_q <= rate_d;
      done_q <= done_d;
    end
  end

  sar_tad_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (on_q),
    .rate (rate_q),
    .tick (tick)
  );

  sar_ctrl #(.BITS(BITS), .SW(SW)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .on_q    (on_q),
    .ctl_we  (ctrl_we),
    .wr_on   (wd.on),
    .wr_go   (wd.go),
    .state   (state),
    .load_sar(load_sar),
    .decide  (decide),
    .idx     (idx),
    .complete(complete)
  );

  sar_reg #(.BITS(BITS), .SW(SW)) sar_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_sar),
    .decide  (decide),
    .idx     (idx),
    .cmp     (cmp_in),
    .code    (dac_code),
    .resolved(resolved)
  );

  sar_result #(.BITS(BITS), .RES_W(RES_W)) res_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (complete),
    .rjust(rj_q),
    .val  (resolved),
    .we_hi(res_we_hi),
    .we_lo(res_we_lo),
    .wdata(res_wdata),
    .hi   (res_hi),
    .lo   (res_lo)
  );

  assign sample_open = (state == ST_CONV);
  assign go_busy     = (state == ST_ARM) || (state == ST_CONV);
  assign acq_on      = on_q && (state == ST_IDLE);
  assign adc_on      = on_q;
  assign done_irq    = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int BITS  = 10,
  parameter int RES_W = 16,
  parameter int CTL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_we,
  input logic [CTL_W-1:0]   ctrl_wdata,
  input logic               res_we_hi,
  input logic               res_we_lo,
  input logic               irq_clr,
  input logic [BITS-1:0]    dac_code,
  input logic               sample_open,
  input logic               acq_on,
  input logic               adc_on,
  input logic               go_busy,
  input logic               done_irq,
  input logic [RES_W/2-1:0] res_hi,
  input logic [RES_W/2-1:0] res_lo
);
  AST_SWITCH_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_open |-> go_busy); // R3

  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> (!go_busy && $past(sample_open))); // R4

  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && (!ctrl_wdata[1] || !ctrl_wdata[0]) && !res_we_hi && !res_we_lo)
      |=> $stable({res_hi, res_lo})); // R5

  AST_RECOVERY_HOLDS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_open) |-> !acq_on); // R6

  AST_NO_ACQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy |-> !acq_on); // R6

  AST_NO_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0] && ctrl_wdata[1] && !adc_on) |=> !go_busy); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !irq_clr) |=> done_irq); // R10

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_open) |-> (dac_code == {1'b1, {(BITS-1){1'b0}}})); // R11
endmodule

bind sar_seq_top sar_seq_chk #(.BITS(BITS), .RES_W(RES_W), .CTL_W(sar_pkg::CTL_W)) chk_i (.*);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ctrl_we;
  logic [4:0] ctrl_wdata;
  logic       res_we_hi, res_we_lo;
  logic [7:0] res_wdata;
  logic       irq_clr;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sample_open, acq_on, adc_on, go_busy, done_irq;
  logic [7:0] res_hi, res_lo;

  logic [9:0]  vin_m;
  logic [15:0] exp_q[$];
  int          total, bad;
  logic        prev_done, prev_busy;

  sar_seq_top dut_i (.*);

  // Comparator model: 1 when the input level is at or above the trial code.
  assign cmp_in = (vin_m >= dac_code);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic on, input logic go, input logic rj, input logic [1:0] rate);
    @(negedge clk);
    ctrl_we    = 1'b1;
    ctrl_wdata = {rate, rj, go, on};
    @(negedge clk);
    ctrl_we    = 1'b0;
  endtask

  task automatic byte_write(input logic hi, input logic [7:0] d);
    @(negedge clk);
    res_we_hi = hi;
    res_we_lo = !hi;
    res_wdata = d;
    @(negedge clk);
    res_we_hi = 1'b0;
    res_we_lo = 1'b0;
  endtask

  task automatic wait_acq(output int n);
    n = 0;
    while (!acq_on && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Driver: pushes the expected word, starts, and checks timing.
  task automatic convert(input logic [9:0] v, input logic rj, input logic [1:0] rate, input int rdiv);
    int cyc;
    int n;
    bit opened;
    vin_m = v;
    exp_q.push_back(rj ? {6'b0, v} : {v, 6'b0});
    ctl_write(1'b1, 1'b1, rj, rate);
    check_eq("R4", "busy after start", int'(go_busy), 1);
    cyc = 0;
    opened = 0;
    while (!done_irq && cyc < 4000) begin
      if (sample_open && !opened) begin
        opened = 1;
        check_eq("R11", "first trial code", int'(dac_code), 'h200);
      end
      @(negedge clk);
      cyc++;
    end
    total++;
    if (cyc < 11 * rdiv + 1 || cyc > 12 * rdiv) begin
      bad++;
      $display("FAIL R1 conversion clocks act=%0d exp=%0d..%0d", cyc, 11 * rdiv + 1, 12 * rdiv);
    end
    check_eq("R3", "switch opened during conversion", int'(opened), 1);
    check_eq("R3", "switch closed at done", int'(sample_open), 0);
    check_eq("R6", "no acquisition at done", int'(acq_on), 0);
    wait_acq(n);
    check_eq("R6", "recovery clocks", n, 2 * rdiv);
    check_eq("R10", "flag still set", int'(done_irq), 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check_eq("R10", "flag cleared", int'(done_irq), 0);
  endtask

  // Monitor: scoreboard compare on each rise of the done flag.
  initial begin
    prev_done = 1'b0;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done_irq && !prev_done) begin
        check_eq("R4", "busy cleared with done", int'(go_busy), 0);
        check_eq("R4", "busy before done", int'(prev_busy), 1);
        if (exp_q.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R2 unexpected result act=%0h exp=none", {res_hi, res_lo});
        end else begin
          check_eq("R2/R7", "result word", int'({res_hi, res_lo}), int'(exp_q.pop_front()));
        end
      end
      prev_done = done_irq;
      prev_busy = go_busy;
    end
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int n;
    int seen;
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    ctrl_we = 1'b0;
    ctrl_wdata = '0;
    res_we_hi = 1'b0;
    res_we_lo = 1'b0;
    res_wdata = '0;
    irq_clr = 1'b0;
    vin_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check_eq("R12", "busy", int'(go_busy), 0);
    check_eq("R12", "flag", int'(done_irq), 0);
    check_eq("R12", "switch", int'(sample_open), 0);
    check_eq("R12", "acq", int'(acq_on), 0);
    check_eq("R12", "on", int'(adc_on), 0);
    check_eq("R12", "result", int'({res_hi, res_lo}), 0);

    // R8 plain storage while off
    byte_write(1'b1, 8'hA5);
    byte_write(1'b0, 8'h3C);
    check_eq("R8", "bytes while off", int'({res_hi, res_lo}), 'hA53C);

    // R9 start in the enabling write is dropped
    ctl_write(1'b1, 1'b1, 1'b1, 2'd0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (go_busy) seen++;
      @(negedge clk);
    end
    check_eq("R9", "no start on enable", seen, 0);
    check_eq("R9", "converter on", int'(adc_on), 1);
    check_eq("R9", "flag untouched", int'(done_irq), 0);
    check_eq("R9", "bytes untouched", int'({res_hi, res_lo}), 'hA53C);
    wait_acq(n);
    check_eq("R6", "acquiring when idle", int'(acq_on), 1);

    // R1 R2 R7: several levels, alignments and rates
    convert(10'h2C7, 1'b1, 2'd0, 2);
    convert(10'h155, 1'b0, 2'd1, 8);
    convert(10'h3FF, 1'b1, 2'd2, 32);
    convert(10'h000, 1'b0, 2'd0, 2);
    convert(10'h200, 1'b1, 2'd3, 32);
    convert(10'h1FF, 1'b0, 2'd1, 8);

    // R5 abort keeps the result; R6 start during recovery dropped
    held = {res_hi, res_lo};
    vin_m = 10'h0F0;
    ctl_write(1'b1, 1'b1, 1'b1, 2'd1);
    n = 0;
    while (!sample_open && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (24) @(negedge clk);
    check_eq("R5", "running before abort", int'(go_busy), 1);
    ctl_write(1'b1, 1'b0, 1'b1, 2'd1);
    check_eq("R5", "busy after abort", int'(go_busy), 0);
    check_eq("R5", "switch after abort", int'(sample_open), 0);
    check_eq("R5", "result after abort", int'({res_hi, res_lo}), int'(held));
    check_eq("R6", "no acquisition after abort", int'(acq_on), 0);
    ctl_write(1'b1, 1'b1, 1'b1, 2'd1);
    check_eq("R6", "start in recovery dropped", int'(go_busy), 0);
    wait_acq(n);
    repeat (20) @(negedge clk);
    check_eq("R6", "still idle", int'(go_busy), 0);
    check_eq("R5", "no flag after abort", int'(done_irq), 0);
    check_eq("R5", "result kept", int'({res_hi, res_lo}), int'(held));

    // Converter off: bytes writable again, then an abort keeps them
    ctl_write(1'b0, 1'b0, 1'b0, 2'd0);
    byte_write(1'b1, 8'h5A);
    byte_write(1'b0, 8'hC3);
    check_eq("R8", "bytes rewritten while off", int'({res_hi, res_lo}), 'h5AC3);
    ctl_write(1'b1, 1'b0, 1'b0, 2'd0);
    wait_acq(n);
    vin_m = 10'h321;
    ctl_write(1'b1, 1'b1, 1'b0, 2'd0);
    repeat (8) @(negedge clk);
    ctl_write(1'b1, 1'b0, 1'b0, 2'd0);
    check_eq("R5", "host bytes kept on abort", int'({res_hi, res_lo}), 'h5AC3);
    wait_acq(n);

    convert(10'h0AB, 1'b1, 2'd0, 2);
    check_eq("R2", "queue drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule